// File: doc/BRIEF.md
# Pull Resistor Latch Sequencer

This block keeps the pull resistor setting (off, pull-down or pull-up) for every pin of a wide general-purpose pin group. Software never writes a pin's pull setting directly. It first places the wanted mode in one shared control register. It then raises that pin's bit in the clock-mask register of the pin's bank, keeps the bit high for a while, and finally returns both registers to zero. Every pin whose mask bit was used in this way takes the mode that was in the control register when its bit rose. It keeps that mode after the registers are zeroed.

Two minimum intervals guard the handshake. One is the setup time from the last accepted control write to the rising mask bit. The other is the hold time from the rising mask write to the falling one. If a mask bit rises too early, a sticky error flag is set and the pin ignores that attempt. If a mask bit falls too early, the attempt is dropped and no flag is set. A pin's setting changes only on the cycle when its mask bit falls, and several pins in one mask move together.

Top module: `pull_latch_seq`

## Requirements
- R1: After reset every pin's pull state is off (code 0) and `setup_err` is 0.
- R2: A write to address 0 with `wr_data[1:0]` equal to 0 (off), 1 (pull-down) or 2 (pull-up) loads the control register and restarts the setup timer. A write of code 3 changes neither the control value nor the timer.
- R3: When a bank's mask bit goes from 0 to 1 on a write that comes at least SETUP_CYC cycles after the last accepted control write, the pin is armed with the control value of that cycle. Later control writes do not change the value it captured.
- R4: A mask bit that goes from 0 to 1 on a write less than SETUP_CYC cycles after the last accepted control write sets `setup_err`, leaves the pin unarmed, and leaves its pull state unchanged.
- R5: When an armed pin's mask bit goes from 1 to 0 on a write at least HOLD_CYC cycles after that bank's latest write that raised any bit, the pin's pull state takes the captured mode. An earlier fall disarms the pin and leaves its state unchanged.
- R6: All pins released in one mask write update together. Pins in other banks and pins whose mask bits did not change keep their state.
- R7: Pull states do not change in any cycle that follows a cycle with no write, and they are held for as long as no write occurs.
- R8: `setup_err` stays set until a write to address 1 with `wr_data[0]`=1. A write to address 1 with `wr_data[0]`=0 has no effect.
- R9: Address map: 0 is control, 1 clears the flag, 2+b is the mask of bank b. Bit i of that mask is pin 32*b+i, and `pull_state[2p+1:2p]` is pin p. Writes to any other address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 32 | Write data |
| pull_state | output | 2*NUM_PINS | Latched pull code per pin |
| setup_err | output | 1 | Sticky early-clock flag |

## Verification
If the setup or hold timer is off by one, a pin latches or fails to latch when the interval is exactly 149 or 150 cycles. This shows in `pull_state` on the cycle after the falling mask write, or in `setup_err` on the cycle after the rising mask write. A wrong armed bit or a wrong captured mode stays hidden until that pin's mask bit falls, and then shows on the same cycle. A bad bank decode moves the wrong pins at that moment. For this reason the random handshakes are checked right after each release, with gaps drawn around both thresholds.

// File: rtl/pull_latch_seq.sv
`timescale 1ns/1ps
module pull_latch_seq #(
  parameter int NUM_PINS  = 64,
  parameter int SETUP_CYC = 150,
  parameter int HOLD_CYC  = 150,
  parameter int ADDR_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  output logic [2*NUM_PINS-1:0] pull_state,
  output logic                  setup_err
);
  localparam int NBANK = (NUM_PINS + 31) / 32;
  localparam int SW    = $clog2(SETUP_CYC + 1);
  localparam int HW    = $clog2(HOLD_CYC + 1);

  logic [1:0]    ctrl_q;
  logic [SW-1:0] setup_cnt;
  logic [NBANK-1:0] bank_viol;
  logic [1:0] st_q [NUM_PINS];

  wire ctrl_wr  = wr_en && wr_addr == ADDR_W'(0) && wr_data[1:0] != 2'd3;
  wire clr_wr   = wr_en && wr_addr == ADDR_W'(1) && wr_data[0];
  wire setup_ok = setup_cnt >= SW'(SETUP_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= 2'd0;
      setup_cnt <= '0;
    end else if (ctrl_wr) begin
      ctrl_q    <= wr_data[1:0];
      setup_cnt <= '0;
    end else if (!setup_ok) begin
      setup_cnt <= setup_cnt + SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          setup_err <= 1'b0;
    else if (clr_wr)     setup_err <= 1'b0;
    else if (|bank_viol) setup_err <= 1'b1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [31:0]   mask_q;
    logic [HW-1:0] hold_cnt;
    wire        bank_wr = wr_en && wr_addr == ADDR_W'(b + 2);
    wire [31:0] rise    = bank_wr ? (wr_data & ~mask_q) : 32'd0;
    wire [31:0] fall    = bank_wr ? (~wr_data & mask_q) : 32'd0;
    wire        hold_ok = hold_cnt >= HW'(HOLD_CYC - 1);

    assign bank_viol[b] = (|rise) && !setup_ok;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q   <= 32'd0;
        hold_cnt <= '0;
      end else begin
        if (bank_wr) mask_q <= wr_data;
        if (|rise)         hold_cnt <= '0;
        else if (!hold_ok) hold_cnt <= hold_cnt + HW'(1);
      end
    end

    for (genvar i = 0; i < 32; i++) begin : g_pin
      if (b * 32 + i < NUM_PINS) begin : g_live
        logic       armed;
        logic [1:0] cap;
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            armed            <= 1'b0;
            cap              <= 2'd0;
            st_q[b * 32 + i] <= 2'd0;
          end else if (rise[i]) begin
            armed <= setup_ok;
            if (setup_ok) cap <= ctrl_q;
          end else if (fall[i]) begin
            armed <= 1'b0;
            if (armed && hold_ok) st_q[b * 32 + i] <= cap;
          end
        end
        assign pull_state[2 * (b * 32 + i) +: 2] = st_q[b * 32 + i];
      end
    end
  end

  assert_reserved_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(0) && wr_data[1:0] == 2'd3) |=> $stable(ctrl_q));

  assert_err_from_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setup_err) |-> $past(wr_en && wr_addr >= ADDR_W'(2)));

  assert_state_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(pull_state));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_err && !clr_wr) |=> setup_err);
endmodule

// File: tb/sim_pull_latch_seq.sv
`timescale 1ns/1ps
module sim_pull_latch_seq;
  localparam int NP = 64, NB = 2, SET = 150, HLD = 150;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2*NP-1:0] pull_state;
  logic setup_err;
  int checks = 0, fails = 0, cyc = 0;

  logic [1:0] exp_st [NP];
  logic [1:0] cap_m [NP];
  logic arm_m [NP];
  logic [31:0] mask_m [NB];
  int rise_cyc [NB];
  logic [1:0] ctrl_m;
  int ctrl_cyc;
  logic err_m;

  always #4 clk = ~clk;

  pull_latch_seq #(.NUM_PINS(NP), .SETUP_CYC(SET), .HOLD_CYC(HLD), .ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pull_state(pull_state), .setup_err(setup_err));

  task automatic tick(); @(negedge clk); cyc++; endtask
  task automatic idle(int n); repeat (n) tick(); endtask

  task automatic model(logic [3:0] a, logic [31:0] d);
    if (a == 0 && d[1:0] != 2'd3) begin ctrl_m = d[1:0]; ctrl_cyc = cyc; end
    if (a == 1 && d[0]) err_m = 1'b0;
    if (a >= 2 && a < 2 + NB) begin
      int b = a - 2;
      logic any_rise = 1'b0;
      for (int i = 0; i < 32; i++) begin
        int p = b * 32 + i;
        if (!mask_m[b][i] && d[i]) begin
          any_rise = 1'b1;
          if (cyc - ctrl_cyc >= SET) begin arm_m[p] = 1'b1; cap_m[p] = ctrl_m; end
          else begin arm_m[p] = 1'b0; err_m = 1'b1; end
        end else if (mask_m[b][i] && !d[i]) begin
          if (arm_m[p] && cyc - rise_cyc[b] >= HLD) exp_st[p] = cap_m[p];
          arm_m[p] = 1'b0;
        end
      end
      if (any_rise) rise_cyc[b] = cyc;
      mask_m[b] = d;
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    tick();
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model(a, d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic seq(int b, logic [31:0] m, logic [1:0] mode, int gs, int gh);
    wr(4'd0, {30'd0, mode});
    idle(gs - 2);
    wr(4'(b + 2), m);
    idle(gh - 4);
    wr(4'd0, 32'd0);
    wr(4'(b + 2), 32'd0);
  endtask

  task automatic check(string tag);
    for (int p = 0; p < NP; p++) begin
      checks++;
      if (pull_state[2*p +: 2] !== exp_st[p]) begin
        fails++;
        $display("FAIL %s pin %0d state actual %0d expected %0d", tag, p, pull_state[2*p +: 2], exp_st[p]);
      end
    end
    checks++;
    if (setup_err !== err_m) begin
      fails++;
      $display("FAIL %s setup_err actual %0b expected %0b", tag, setup_err, err_m);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) begin exp_st[p] = 0; cap_m[p] = 0; arm_m[p] = 0; end
    for (int b = 0; b < NB; b++) begin mask_m[b] = 0; rise_cyc[b] = 0; end
    ctrl_m = 0; ctrl_cyc = 0; err_m = 0;
    idle(5);
    rst_n = 1'b1;
    tick();
    check("R1 reset");

    seq(0, 32'h8, 2'd2, 150, 150);          check("R3 R5 exact thresholds");
    seq(0, 32'h10, 2'd1, 149, 200);         check("R4 setup one short");
    wr(4'd1, 32'd0);                        check("R8 clear with bit0 low");
    wr(4'd1, 32'd1);                        check("R8 clear");
    seq(1, 32'h81, 2'd1, 200, 149);         check("R5 hold one short");
    seq(1, 32'h8001_0081, 2'd1, 300, 150);  check("R6 multi pin bank1");
    idle(500);                              check("R7 held after zero");
    seq(0, 32'h8, 2'd3, 200, 200);          check("R2 reserved code ignored");
    wr(4'd9, 32'hFFFF_FFFF);                check("R9 unmapped address");
    seq(0, 32'h1, 2'd2, 160, 160);          check("R9 bank0 bit0 pin0");

    for (int k = 0; k < 40; k++) begin
      int b = $urandom % NB;
      logic [31:0] m = $urandom & $urandom & $urandom;
      logic [1:0] mode = 2'($urandom % 4);
      int gs = 140 + $urandom % 25;
      int gh = 140 + $urandom % 25;
      seq(b, m, mode, gs, gh);
      check("R3 R4 R5 R6 random");
      if ($urandom % 3 == 0) begin wr(4'd1, 32'd1); check("R8 random clear"); end
      if ($urandom % 4 == 0) begin wr(4'(6 + $urandom % 10), $urandom); check("R9 random ignore"); end
    end
    summary();
  end
endmodule